// File: doc/BRIEF.md
# Bridge ADC Power-Up Sequencer

This block brings an external 24-bit bridge ADC from reset into a configured, converting state with no help from software. It reaches the converter's byte-wide registers through a plain access port. The port carries a write flag, an 8-bit address and 8-bit write data, and returns read data together with a completion pulse and an error flag. An I2C master, which is not part of this block, would normally serve that port.

A start pulse samples the configured supply voltage in millivolts and runs a fixed chain of register accesses. The chain resets the converter's registers and powers up its digital core. It then waits a programmed time and confirms the power-ready status bit. Next it enables the analog core and conversion cycling and selects either the external supply or the internal regulator, and it loads the ADC control byte. When the internal regulator is used, the last access programs the regulator code.

The result is reported on two flags, `seq_done` and `seq_failed`. The regulator voltage actually programmed is also presented as an output.

The states are:
- `ST_IDLE`
- `ST_RST_WR`: register-reset write
- `ST_DPU_WR`: digital power-up write
- `ST_PU_WAIT`: timed wait
- `ST_STAT_RD`: status read
- `ST_PWR_WR`: full power write
- `ST_ADC_WR`: ADC control write
- `ST_LDO_WR`: regulator write

The transitions are:
- `ST_IDLE` moves to `ST_RST_WR` on start.
- Each write state advances to the next state when its transfer completes without error.
- `ST_DPU_WR` leads to `ST_PU_WAIT`, which leads to `ST_STAT_RD` when the timer expires.
- `ST_STAT_RD` goes to `ST_PWR_WR` if the ready bit is set, and to `ST_IDLE` with a failure otherwise.
- `ST_ADC_WR` goes to `ST_LDO_WR` when the internal regulator is selected, or to `ST_IDLE` with done otherwise.
- `ST_LDO_WR` returns to `ST_IDLE` with done.
- Any completion flagged with an error returns to `ST_IDLE` with a failure.

Top module: `adc_pwrup_seq`

## Requirements
- R1: After reset, `acc_req`, `seq_done` and `seq_failed` are low and `ldo_mv` is zero.
- R2: A start pulse in idle produces a write of 0x01 to address 0x00, followed by a write of 0x02 to address 0x00.
- R3: After the second write completes, `acc_req` stays low for exactly ceil(CLK_HZ*WAIT_US/1e6) cycles. A read of address 0x00 (`acc_we` low) follows.
- R4: If the read byte has bit 3 (power ready) clear, the sequence ends with `seq_failed` high and issues no further access.
- R5: The next access writes address 0x00 with bits 1, 2 and 4 set (0x16). Bit 7 is also set (0x96) when the sampled voltage is 2400 mV or more.
- R6: The next access writes 0x30 to address 0x15.
- R7: When the sampled voltage is 2400 mV or more, a final write to address 0x01 carries code<<3 with all other bits zero. The code is floor((4500-mV)/300), or 0 for 4500 mV and above. Below 2400 mV this write is skipped.
- R8: One cycle after the last completion, `seq_done` is high and `acc_req` is low. `ldo_mv` shows 4500-300*code when the regulator was programmed, and 0 otherwise.
- R9: A completion with `acc_err` high at any step returns to idle with `seq_failed` high. No further access is issued. `seq_done` and `seq_failed` are never high together.
- R10: Once raised, `acc_req`, `acc_we`, `acc_addr` and `acc_wdata` hold steady until `acc_done`.
- R11: A start pulse during a running sequence is ignored. `cfg_mv` is sampled only at an accepted start, so later changes do not alter the sequence.
- R12: An accepted start clears `seq_done`, `seq_failed` and `ldo_mv` and restarts from the reset write, including after a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a sequence when idle |
| cfg_mv | input | MV_W | Supply voltage setting in millivolts |
| acc_req | output | 1 | Access request, held until acc_done |
| acc_we | output | 1 | 1 = write, 0 = read |
| acc_addr | output | 8 | Register address |
| acc_wdata | output | 8 | Write data |
| acc_rdata | input | 8 | Read data, valid with acc_done |
| acc_done | input | 1 | One-cycle completion of the current access |
| acc_err | input | 1 | Error flag, qualified by acc_done |
| seq_done | output | 1 | Sequence completed successfully (held until next start) |
| seq_failed | output | 1 | Sequence aborted (held until next start) |
| ldo_mv | output | MV_W | Programmed regulator voltage in mV, 0 when external supply |

## Verification
A wrong state register shows as a wrong address, direction or data byte on the access port. It can also show as a request raised or dropped out of turn. Either appears on the very next access cycle, because every state drives the port.

A miscounting wait timer moves the status read early or late by whole cycles. This is visible in the length of the request-low gap.

A bad voltage latch or regulator calculation shows up in bit 7 of the power write, in the regulator write's data byte or presence, or in `ldo_mv` one cycle after the last completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int ACC_AW = 8;
    localparam int ACC_DW = 8;

    // converter register addresses
    localparam logic [ACC_AW-1:0] REG_PWR_CTL = 8'h00;
    localparam logic [ACC_AW-1:0] REG_LDO_CTL = 8'h01;
    localparam logic [ACC_AW-1:0] REG_ADC_CTL = 8'h15;

    // power-control bit positions
    localparam int PWR_RESET_BIT = 0;
    localparam int PWR_DIG_BIT   = 1;
    localparam int PWR_ANA_BIT   = 2;
    localparam int PWR_RDY_BIT   = 3;
    localparam int PWR_CYC_BIT   = 4;
    localparam int PWR_LDOSEL_BIT = 7;

    localparam logic [ACC_DW-1:0] ADC_CTL_VALUE = 8'h30;

    // regulator code field
    localparam int LDO_CODE_W   = 3;
    localparam int LDO_FIELD_LSB = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_WR,
        ST_DPU_WR,
        ST_PU_WAIT,
        ST_STAT_RD,
        ST_PWR_WR,
        ST_ADC_WR,
        ST_LDO_WR
    } seq_state_e;

endpackage

// File: rtl/pu_wait_timer.sv
module pu_wait_timer #(
    parameter int CYCLES = 26250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/ldo_code_calc.sv
module ldo_code_calc
    import adc_seq_pkg::*;
#(
    parameter int MV_W        = 13,
    parameter int LDO_MAX_MV  = 4500,
    parameter int LDO_MIN_MV  = 2400,
    parameter int LDO_STEP_MV = 300
) (
    input  logic [MV_W-1:0]       mv,
    output logic                  use_ldo,
    output logic [LDO_CODE_W-1:0] code,
    output logic [MV_W-1:0]       prog_mv
);
    localparam logic [MV_W-1:0] MAX_V  = MV_W'(LDO_MAX_MV);
    localparam logic [MV_W-1:0] MIN_V  = MV_W'(LDO_MIN_MV);
    localparam logic [MV_W-1:0] STEP_V = MV_W'(LDO_STEP_MV);
    localparam logic [MV_W-1:0] CODE_SAT = MV_W'((1 << LDO_CODE_W) - 1);

    logic [MV_W-1:0] diff;
    logic [MV_W-1:0] quot;

    always_comb begin
        use_ldo = (mv >= MIN_V);
        diff    = (mv >= MAX_V) ? '0 : (MAX_V - mv);
        quot    = diff / STEP_V;
        code    = (quot > CODE_SAT) ? CODE_SAT[LDO_CODE_W-1:0] : quot[LDO_CODE_W-1:0];
        prog_mv = MAX_V - (MV_W'(code) * STEP_V);
    end

endmodule

// File: rtl/adc_pwrup_seq.sv
module adc_pwrup_seq
    import adc_seq_pkg::*;
#(
    parameter int CLK_HZ  = 125_000_000,
    parameter int WAIT_US = 210,
    parameter int MV_W    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MV_W-1:0]   cfg_mv,
    output logic              acc_req,
    output logic              acc_we,
    output logic [ACC_AW-1:0] acc_addr,
    output logic [ACC_DW-1:0] acc_wdata,
    input  logic [ACC_DW-1:0] acc_rdata,
    input  logic              acc_done,
    input  logic              acc_err,
    output logic              seq_done,
    output logic              seq_failed,
    output logic [MV_W-1:0]   ldo_mv
);
    localparam longint unsigned WAIT_PROD = 64'(CLK_HZ) * 64'(WAIT_US);
    localparam int WAIT_RAW = int'((WAIT_PROD + 64'd999_999) / 64'd1_000_000);
    localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

    seq_state_e state_q, state_d;
    logic [MV_W-1:0]       mv_q;
    logic                  use_ldo;
    logic [LDO_CODE_W-1:0] ldo_code;
    logic [MV_W-1:0]       prog_mv;
    logic                  wait_exp;
    logic                  xfer_ok, xfer_bad;
    logic                  finish_ok, abort;
    logic                  unused_rdata;

    assign unused_rdata = ^acc_rdata;

    ldo_code_calc #(.MV_W(MV_W)) u_ldo (
        .mv      (mv_q),
        .use_ldo (use_ldo),
        .code    (ldo_code),
        .prog_mv (prog_mv)
    );

    pu_wait_timer #(.CYCLES(WAIT_CYC)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_PU_WAIT),
        .expired (wait_exp)
    );

    assign xfer_ok  = acc_req && acc_done && !acc_err;
    assign xfer_bad = acc_req && acc_done && acc_err;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d   = state_q;
        finish_ok = 1'b0;
        abort     = 1'b0;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_RST_WR;
            ST_RST_WR:  if (xfer_ok) state_d = ST_DPU_WR;
            ST_DPU_WR:  if (xfer_ok) state_d = ST_PU_WAIT;
            ST_PU_WAIT: if (wait_exp) state_d = ST_STAT_RD;
            ST_STAT_RD: begin
                if (xfer_ok) begin
                    if (acc_rdata[PWR_RDY_BIT]) begin
                        state_d = ST_PWR_WR;
                    end else begin
                        state_d = ST_IDLE;
                        abort   = 1'b1;
                    end
                end
            end
            ST_PWR_WR:  if (xfer_ok) state_d = ST_ADC_WR;
            ST_ADC_WR: begin
                if (xfer_ok) begin
                    if (use_ldo) begin
                        state_d = ST_LDO_WR;
                    end else begin
                        state_d   = ST_IDLE;
                        finish_ok = 1'b1;
                    end
                end
            end
            ST_LDO_WR: begin
                if (xfer_ok) begin
                    state_d   = ST_IDLE;
                    finish_ok = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (xfer_bad) begin
            state_d   = ST_IDLE;
            abort     = 1'b1;
            finish_ok = 1'b0;
        end
    end

    // access port outputs
    always_comb begin
        acc_req   = 1'b0;
        acc_we    = 1'b0;
        acc_addr  = '0;
        acc_wdata = '0;
        unique case (state_q)
            ST_IDLE, ST_PU_WAIT: begin
                acc_req = 1'b0;
            end
            ST_RST_WR: begin
                acc_req = 1'b1;
                acc_we  = 1'b1;
                acc_addr = REG_PWR_CTL;
                acc_wdata[PWR_RESET_BIT] = 1'b1;
            end
            ST_DPU_WR: begin
                acc_req = 1'b1;
                acc_we  = 1'b1;
                acc_addr = REG_PWR_CTL;
                acc_wdata[PWR_DIG_BIT] = 1'b1;
            end
            ST_STAT_RD: begin
                acc_req  = 1'b1;
                acc_addr = REG_PWR_CTL;
            end
            ST_PWR_WR: begin
                acc_req = 1'b1;
                acc_we  = 1'b1;
                acc_addr = REG_PWR_CTL;
                acc_wdata[PWR_DIG_BIT]    = 1'b1;
                acc_wdata[PWR_ANA_BIT]    = 1'b1;
                acc_wdata[PWR_CYC_BIT]    = 1'b1;
                acc_wdata[PWR_LDOSEL_BIT] = use_ldo;
            end
            ST_ADC_WR: begin
                acc_req   = 1'b1;
                acc_we    = 1'b1;
                acc_addr  = REG_ADC_CTL;
                acc_wdata = ADC_CTL_VALUE;
            end
            ST_LDO_WR: begin
                acc_req   = 1'b1;
                acc_we    = 1'b1;
                acc_addr  = REG_LDO_CTL;
                acc_wdata = ACC_DW'(ldo_code) << LDO_FIELD_LSB;
            end
            default: acc_req = 1'b0;
        endcase
    end

    // sampled setting and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mv_q       <= '0;
            seq_done   <= 1'b0;
            seq_failed <= 1'b0;
            ldo_mv     <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                mv_q       <= cfg_mv;
                seq_done   <= 1'b0;
                seq_failed <= 1'b0;
                ldo_mv     <= '0;
            end
            if (abort) seq_failed <= 1'b1;
            if (finish_ok) begin
                seq_done <= 1'b1;
                ldo_mv   <= (state_q == ST_LDO_WR) ? prog_mv : '0;
            end
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_done |=> acc_req && $stable(acc_we) && $stable(acc_addr) && $stable(acc_wdata));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_failed));

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !acc_req);

    // R4
    fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_failed) |-> $past(acc_done));

    // R7
    ldo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_we && acc_addr == REG_LDO_CTL |-> use_ldo);

endmodule

// File: tb/sim_adc_pwrup_seq.sv
module sim_adc_pwrup_seq;
    localparam int CLK_HZ  = 2_000_000;
    localparam int WAIT_US = 210;
    localparam int W = (CLK_HZ * WAIT_US + 999_999) / 1_000_000;

    logic        clk = 1'b0;
    logic        rst_n, start, acc_done, acc_err;
    logic [12:0] cfg_mv;
    logic        acc_req, acc_we, seq_done, seq_failed;
    logic [7:0]  acc_addr, acc_wdata, acc_rdata;
    logic [12:0] ldo_mv;

    always #4 clk = ~clk;

    adc_pwrup_seq #(.CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US), .MV_W(13)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mv(cfg_mv),
        .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_done(acc_done), .acc_err(acc_err),
        .seq_done(seq_done), .seq_failed(seq_failed), .ldo_mv(ldo_mv)
    );

    int n_chk = 0, n_fail = 0;
    logic [16:0] q[$];
    logic [16:0] hd;
    int  tx_idx = 0, wait_left = 0, lat_cnt = 0, n_starts = 0;
    bit  running = 0, done_drv = 0, go = 0, er;
    int  cfg_lat = 0, cfg_err_at = -1, run_mv = 0, final_ldo = 0;
    bit  cfg_poke = 0;
    logic [7:0] cfg_stat = 8'h08;
    bit  exp_done = 0, exp_failed = 0;
    int  exp_ldo = 0;
    string tag;

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic build(input int mv);
        int code;
        code = (mv >= 4500) ? 0 : (4500 - mv) / 300;
        q.delete();
        q.push_back({1'b1, 8'h00, 8'h01});
        q.push_back({1'b1, 8'h00, 8'h02});
        q.push_back({1'b0, 8'h00, 8'h00});
        q.push_back({1'b1, 8'h00, (mv >= 2400) ? 8'h96 : 8'h16});
        q.push_back({1'b1, 8'h15, 8'h30});
        if (mv >= 2400) q.push_back({1'b1, 8'h01, 8'(code << 3)});
        final_ldo = (mv >= 2400) ? 4500 - 300 * code : 0;
    endtask

    function automatic string head_tag(input int idx);
        case (idx)
            0, 1:    return "R2";
            2:       return "R3";
            3:       return "R5";
            4:       return "R6";
            default: return "R7";
        endcase
    endfunction

    // reference model: compare then drive, every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            er = running && q.size() > 0 && wait_left == 0;
            if (!running)           tag = exp_failed ? "R9" : "R8";
            else if (wait_left > 0) tag = "R3";
            else if (lat_cnt > 0)   tag = "R10";
            else                    tag = head_tag(tx_idx);
            chk(acc_req === er, tag, int'(acc_req), int'(er));
            if (er && acc_req)
                chk(acc_we === q[0][16] && acc_addr === q[0][15:8] &&
                    (!q[0][16] || acc_wdata === q[0][7:0]),
                    tag, int'({acc_we, acc_addr, acc_wdata}), int'(q[0]));
            chk(seq_done === exp_done, "R8", int'(seq_done), int'(exp_done));
            chk(seq_failed === exp_failed, "R9", int'(seq_failed), int'(exp_failed));
            chk(int'(ldo_mv) == exp_ldo, "R8", int'(ldo_mv), exp_ldo);

            start = 1'b0;
            if (wait_left > 0) wait_left--;
            if (done_drv) begin
                acc_done = 1'b0;
                acc_err  = 1'b0;
                done_drv = 0;
            end else if (er && lat_cnt >= cfg_lat) begin
                hd = q.pop_front();
                acc_done  = 1'b1;
                done_drv  = 1;
                lat_cnt   = 0;
                acc_err   = (tx_idx == cfg_err_at);
                acc_rdata = hd[16] ? 8'hA5 : cfg_stat;
                if (acc_err || (!hd[16] && !cfg_stat[3])) begin
                    running = 0;
                    q.delete();
                    exp_failed = 1;
                end else begin
                    if (tx_idx == 1) wait_left = W;
                    if (q.size() == 0) begin
                        running  = 0;
                        exp_done = 1;
                        exp_ldo  = final_ldo;
                    end
                end
                tx_idx++;
            end else if (er) begin
                lat_cnt++;
            end
            // R11: start and a new voltage while busy must change nothing
            if (cfg_poke && running && wait_left == W / 2) begin
                start    = 1'b1;
                cfg_mv   = 13'd1000;
                cfg_poke = 0;
            end
            if (go) begin
                go = 0;
                start  = 1'b1;
                cfg_mv = 13'(run_mv);
                build(run_mv);
                running = 1;
                tx_idx  = 0;
                lat_cnt = 0;
                exp_done = 0;
                exp_failed = 0;
                exp_ldo = 0;
                n_starts++;
            end
        end
    end

    task automatic do_run(input int mv, input int lat, input logic [7:0] stat,
                          input int err_at, input bit poke);
        int s;
        @(posedge clk);
        run_mv = mv; cfg_lat = lat; cfg_stat = stat; cfg_err_at = err_at; cfg_poke = poke;
        s = n_starts;
        go = 1;
        wait (n_starts != s);
        @(negedge clk);
        #1;
        // R12: flags cleared and reset write under way one cycle after start
        chk(!seq_done && !seq_failed && acc_req && acc_addr == 8'h00 && acc_wdata == 8'h01,
            "R12", int'({seq_done, seq_failed, acc_req}), 1);
        while (running) @(negedge clk);
        repeat (3) @(negedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; cfg_mv = '0;
        acc_done = 1'b0; acc_err = 1'b0; acc_rdata = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!acc_req && !seq_done && !seq_failed && ldo_mv == 0, "R1",
            int'({acc_req, seq_done, seq_failed}), 0);

        do_run(3300, 0, 8'h08, -1, 0);
        chk(seq_done && ldo_mv == 13'd3300, "R8", int'(ldo_mv), 3300);
        do_run(1800, 2, 8'h08, -1, 0);
        chk(seq_done && ldo_mv == 0 && tx_idx == 5, "R7", tx_idx, 5);
        do_run(2400, 1, 8'h08, -1, 0);
        chk(ldo_mv == 13'd2400, "R7", int'(ldo_mv), 2400);
        do_run(2399, 0, 8'h08, -1, 0);
        chk(seq_done && ldo_mv == 0, "R5", int'(ldo_mv), 0);
        do_run(5000, 3, 8'h08, -1, 0);
        chk(ldo_mv == 13'd4500, "R7", int'(ldo_mv), 4500);
        do_run(3000, 0, 8'hF7, -1, 0);
        chk(seq_failed && !seq_done && tx_idx == 3, "R4", tx_idx, 3);
        do_run(3300, 1, 8'h08, -1, 1);
        chk(seq_done && ldo_mv == 13'd3300, "R11", int'(ldo_mv), 3300);
        do_run(4200, 0, 8'h08, 0, 0);
        chk(seq_failed && !seq_done && tx_idx == 1, "R9", tx_idx, 1);
        do_run(4200, 1, 8'h08, 4, 0);
        chk(seq_failed && ldo_mv == 0 && tx_idx == 5, "R9", tx_idx, 5);
        do_run(4200, 0, 8'hF8, -1, 0);
        chk(seq_done && ldo_mv == 13'd4200, "R12", int'(ldo_mv), 4200);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule